// File: doc/BRIEF.md
# Stepped Soft-Start Reference Sequencer

This block produces the digital reference code that a power converter's regulation loop compares its feedback against. While the converter is held off, the code sits at zero. A start request begins a ramp. The block counts oscillator ticks and raises the code one step at a time until it reaches full scale. It then holds at full scale and raises a done flag.

The default configuration uses 127 equal steps, one every 16 ticks. The first step comes after a lead-in of 31 ticks, so the final step lands exactly on the 2047th tick. A DAC outside the block turns the code into the reference voltage. Full scale corresponds to the loop's nominal reference, and each step is roughly 1/127 of it.

The start input is meant to be pulsed whenever lockout is released or the converter comes back from a fault. A pulse at any time restarts the ramp from zero. If the oscillator stops ticking, the output freezes wherever it is.

Top module: `soft_start_ref`

## Requirements
- R1: While rst_ni is low, and after it is released, ref_code_o is 0 and done_o is 0.
- R2: Before the first start request after reset, tick_i pulses have no effect: ref_code_o stays 0 and done_o stays 0.
- R3: A clock edge with start_i high sets ref_code_o to 0, clears done_o and restarts the tick count from zero. A tick_i in the same cycle is not counted.
- R4: After N ticks counted since the last start, ref_code_o equals max(0, floor((N+1)/STEP_TICKS) - 1). With the defaults, the first step lands on tick 31 and every 16th tick after that.
- R5: Apart from a start, ref_code_o never decreases and never moves by more than one code per clock.
- R6: On tick number STEPS*STEP_TICKS + STEP_TICKS - 1 (2047 by default), ref_code_o reaches STEPS (127) and done_o rises at the same edge. Both then hold under any further ticks, and done_o is high only when ref_code_o equals STEPS.
- R7: In a cycle with tick_i and start_i both low, ref_code_o and done_o keep their values.
- R8: A start during the ramp or during hold restarts the ramp from zero under the same timing as R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per oscillator cycle |
| start_i | input | 1 | Start or restart request, sampled at the clock edge |
| ref_code_o | output | CODE_W | Reference code, 0 to STEPS |
| done_o | output | 1 | High once the ramp has reached full scale |

## Verification
The hardest conditions to reach are the lead-in boundary (ticks 15, 16 and 31) and the final step at tick 2047. Only a long, exactly counted run of ticks gets there. The bench therefore walks every tick count from 0 past 2047 and compares the code after each tick with the closed-form formula. Idle cycles are inserted between ticks at irregular spacing, which shows the output frozen. The bench also issues restarts mid-ramp, in hold, and in the same cycle as a tick, then replays part of the ramp to confirm the count restarted from zero.

// File: rtl/ss_ref_pkg.sv
package ss_ref_pkg;
  typedef enum logic [1:0] {
    SS_IDLE = 2'd0,
    SS_RAMP = 2'd1,
    SS_HOLD = 2'd2
  } ss_state_e;
endpackage

// File: rtl/ss_step_pacer.sv
// Divides counted ticks into step strobes: a lead-in of one full period, then
// one strobe at the last phase of every period.
module ss_step_pacer #(
  parameter int STEP_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic en_i,
  output logic step_o
);
  localparam int PH_W = (STEP_TICKS > 2) ? $clog2(STEP_TICKS) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(STEP_TICKS - 1);
  localparam logic [PH_W-1:0] PH_PRE  = PH_W'(STEP_TICKS - 2);

  logic [PH_W-1:0] phase_q;
  logic            armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      armed_q <= 1'b0;
    end else if (clear_i) begin
      phase_q <= '0;
      armed_q <= 1'b0;
    end else if (en_i) begin
      if (phase_q == PH_LAST) begin
        phase_q <= '0;
        armed_q <= 1'b1;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign step_o = en_i && armed_q && (phase_q == PH_PRE);
endmodule

// File: rtl/ss_code_reg.sv
module ss_code_reg #(
  parameter int STEPS  = 127,
  parameter int CODE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              inc_i,
  output logic [CODE_W-1:0] code_o,
  output logic              last_o
);
  localparam logic [CODE_W-1:0] CODE_PRE = CODE_W'(STEPS - 1);

  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      code_q <= '0;
    else if (clear_i) code_q <= '0;
    else if (inc_i)   code_q <= code_q + 1'b1;
  end

  assign code_o = code_q;
  assign last_o = (code_q == CODE_PRE);
endmodule

// File: rtl/ss_ramp_ctrl.sv
module ss_ramp_ctrl
  import ss_ref_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  input  logic step_i,
  input  logic last_i,
  output logic count_en_o,
  output logic clear_o,
  output logic hold_o
);
  ss_state_e state_q, state_d;

  assign clear_o    = start_i;
  assign count_en_o = tick_i && !start_i && (state_q == SS_RAMP);

  always_comb begin
    state_d = state_q;
    if (start_i) state_d = SS_RAMP;
    else if (state_q == SS_RAMP && step_i && last_i) state_d = SS_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SS_IDLE;
    else         state_q <= state_d;
  end

  assign hold_o = (state_q == SS_HOLD);
endmodule

// File: rtl/soft_start_ref.sv
module soft_start_ref #(
  parameter int STEPS      = 127,
  parameter int STEP_TICKS = 16,
  parameter int CODE_W     = $clog2(STEPS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  output logic [CODE_W-1:0] ref_code_o,
  output logic              done_o
);
  logic count_en, clear, step, last;

  ss_ramp_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .tick_i     (tick_i),
    .step_i     (step),
    .last_i     (last),
    .count_en_o (count_en),
    .clear_o    (clear),
    .hold_o     (done_o)
  );

  ss_step_pacer #(.STEP_TICKS(STEP_TICKS)) u_pacer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .en_i    (count_en),
    .step_o  (step)
  );

  ss_code_reg #(.STEPS(STEPS), .CODE_W(CODE_W)) u_code (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .inc_i   (step),
    .code_o  (ref_code_o),
    .last_o  (last)
  );
endmodule

// File: rtl/soft_start_ref_chk.sv
module soft_start_ref_chk #(
  parameter int STEPS      = 127,
  parameter int STEP_TICKS = 16,
  parameter int CODE_W     = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              start_i,
  input logic [CODE_W-1:0] ref_code_o,
  input logic              done_o
);
  localparam int TOTAL = STEPS * STEP_TICKS + STEP_TICKS - 1;
  localparam int CW    = $clog2(TOTAL + 2) + 1;

  logic          run_q;
  logic [CW-1:0] tcnt_q;

  // Independent count of ticks since the last start.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      tcnt_q <= '0;
    end else if (start_i) begin
      run_q  <= 1'b1;
      tcnt_q <= '0;
    end else if (tick_i && run_q && tcnt_q < CW'(TOTAL)) begin
      tcnt_q <= tcnt_q + 1'b1;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |=> (ref_code_o == '0 && !done_o));

  a_r2_no_run_no_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (ref_code_o == '0 && !done_o));

  a_r3_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (ref_code_o == '0 && !done_o));

  a_r4_step_on_grid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_code_o != $past(ref_code_o) && !$past(start_i)) |->
      ((int'(tcnt_q) + 1) % STEP_TICKS == 0 &&
       int'(ref_code_o) == (int'(tcnt_q) + 1) / STEP_TICKS - 1));

  a_r5_single_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (ref_code_o >= $past(ref_code_o) &&
                  ref_code_o - $past(ref_code_o) <= CODE_W'(1)));

  a_r6_done_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ref_code_o == CODE_W'(STEPS)));

  a_r6_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  a_r7_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !start_i) |=> ($stable(ref_code_o) && $stable(done_o)));
endmodule

bind soft_start_ref soft_start_ref_chk #(
  .STEPS(STEPS), .STEP_TICKS(STEP_TICKS), .CODE_W(CODE_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .start_i    (start_i),
  .ref_code_o (ref_code_o),
  .done_o     (done_o)
);

// File: tb/tb_soft_start_ref.sv
module tb_soft_start_ref;
  localparam int STEPS      = 127;
  localparam int STEP_TICKS = 16;
  localparam int CODE_W     = $clog2(STEPS + 1);
  localparam int TOTAL      = STEPS * STEP_TICKS + STEP_TICKS - 1;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              tick_i = 1'b0;
  logic              start_i = 1'b0;
  logic [CODE_W-1:0] ref_code_o;
  logic              done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  soft_start_ref #(.STEPS(STEPS), .STEP_TICKS(STEP_TICKS)) dut (
    .clk_i, .rst_ni, .tick_i, .start_i, .ref_code_o, .done_o
  );

  function automatic int exp_code(int n);
    int k;
    if (n > TOTAL) n = TOTAL;
    k = (n + 1) / STEP_TICKS - 1;
    return (k < 0) ? 0 : k;
  endfunction

  task automatic check(string req, int exp_c, bit exp_d);
    n_chk++;
    if (int'(ref_code_o) != exp_c || done_o != exp_d) begin
      n_bad++;
      $display("FAIL %s: code=%0d done=%0b expected code=%0d done=%0b",
               req, ref_code_o, done_o, exp_c, exp_d);
    end
  endtask

  task automatic cyc(bit t, bit s);
    tick_i  = t;
    start_i = s;
    @(posedge clk_i);
    #1;
    tick_i  = 1'b0;
    start_i = 1'b0;
  endtask

  initial begin
    int n;
    #1;
    check("R1", 0, 0);
    repeat (3) @(posedge clk_i);
    #1;
    rst_ni = 1'b1;
    check("R1", 0, 0);

    // R2: ticks before any start are ignored
    for (int i = 0; i < 40; i++) begin
      cyc(1, 0);
      check("R2", 0, 0);
    end

    // R3/R4/R6/R7: full sweep with irregular idle gaps
    cyc(1, 1);
    check("R3", 0, 0);
    n = 0;
    for (int i = 0; i < TOTAL + 40; i++) begin
      cyc(1, 0);
      n++;
      check((n >= TOTAL) ? "R6" : "R4", exp_code(n), n >= TOTAL);
      if ((i % 7) == 3) begin
        cyc(0, 0);
        check("R7", exp_code(n), n >= TOTAL);
      end
    end

    // R8: restart during hold
    cyc(0, 1);
    check("R8", 0, 0);
    n = 0;
    for (int i = 0; i < 600; i++) begin
      cyc(1, 0);
      n++;
      check("R8", exp_code(n), 0);
    end

    // R3/R8: restart mid-ramp with a simultaneous tick
    cyc(1, 1);
    check("R3", 0, 0);
    n = 0;
    for (int i = 0; i < 120; i++) begin
      cyc(1, 0);
      n++;
      check("R8", exp_code(n), 0);
      repeat (2) cyc(0, 0);
      check("R7", exp_code(n), 0);
    end

    // R5: back-to-back restarts keep code at zero
    for (int i = 0; i < 20; i++) begin
      cyc(1, 1);
      check("R5", 0, 0);
    end

    // R1: reset in mid-ramp
    for (int i = 0; i < 50; i++) cyc(1, 0);
    rst_ni = 1'b0;
    #1;
    check("R1", 0, 0);
    @(posedge clk_i);
    #1;
    rst_ni = 1'b1;
    for (int i = 0; i < 40; i++) cyc(1, 0);
    check("R2", 0, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule